// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Programmable Anti-Backlash

This block compares a divided reference pulse train with a divided oscillator pulse train and drives the up and down enables of a charge pump. A flag is set for each input on its rising edge. The input whose edge comes first keeps its own enable on alone. When the other edge arrives, both enables are held on together for a minimum anti-backlash window, and then both are cleared. This removes the dead zone around zero phase error. A third output reports when neither enable is on, which is the point at which the pump output would float.

A polarity input swaps the up and down roles. A 2-bit code selects one of four anti-backlash widths, counted in cycles of the fast sampling clock. A lock-detect output goes low for as long as exactly one input is ahead, so its low time tracks the phase difference. For the widest code only, it also goes low during the anti-backlash window. Standby forces the pump outputs to float and the lock output high, and it discards any pending comparison.

The controller is a four-state machine:
- `ST_IDLE`: no edge pending.
- `ST_REF_AHEAD`: the reference edge was seen first.
- `ST_VCO_AHEAD`: the oscillator edge was seen first.
- `ST_BACKLASH`: both edges were seen and the window is being timed.

Its transitions are:
- IDLE to REF_AHEAD on a reference edge alone.
- IDLE to VCO_AHEAD on an oscillator edge alone.
- IDLE to BACKLASH on simultaneous edges.
- REF_AHEAD to BACKLASH on an oscillator edge.
- VCO_AHEAD to BACKLASH on a reference edge.
- BACKLASH to IDLE when the window count expires.
- Any state to IDLE while standby is high.

Top module: `pfd_antibacklash`

## Requirements
- R1: With `pol_pos`=1, a rising edge on `ref_div` while idle makes `pump_up`=1, `pump_dn`=0 and `pump_hiz`=0 from the first clock edge that samples it. This holds until the `vco_div` edge arrives.
- R2: With `pol_pos`=1, a rising edge on `vco_div` while idle makes `pump_dn`=1, `pump_up`=0 and `pump_hiz`=0 until the `ref_div` edge arrives.
- R3: With no comparison pending, `pump_up`=0, `pump_dn`=0 and `pump_hiz`=1.
- R4: With `pol_pos`=0, the roles of `pump_up` and `pump_dn` in R1, R2, R5 and R6 are exchanged.
- R5: Once the lagging edge is sampled, `pump_up` and `pump_dn` are both 1 for exactly W clock cycles and then both return to 0. W is 1, 4, 8 or 10 for `ab_sel` = 0, 1, 2 or 3.
- R6: Rising edges sampled on both inputs in the same cycle go straight to the both-on window of R5.
- R7: `lock_det` is 0 while exactly one input is ahead and 1 while idle.
- R8: During the anti-backlash window, `lock_det` is 1 for `ab_sel` 0, 1 and 2, and 0 for `ab_sel` 3.
- R9: While `standby`=1, `pump_hiz`=1, `pump_up`=`pump_dn`=0 and `lock_det`=1. A pending comparison is discarded, so the block is idle after `standby` falls.
- R10: A repeated edge of the leading input while it is ahead, and any edge during the anti-backlash window, is ignored.
- R11: After reset, `pump_hiz`=1 and `lock_det`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference pulse |
| vco_div | input | 1 | Divided oscillator pulse |
| pol_pos | input | 1 | 1: reference ahead drives up; 0: swapped |
| ab_sel | input | 2 | Anti-backlash width select |
| standby | input | 1 | Forces float, lock high, clears state |
| pump_up | output | 1 | Up current enable |
| pump_dn | output | 1 | Down current enable |
| pump_hiz | output | 1 | Both enables off (float) |
| lock_det | output | 1 | High when locked, low for phase error |

## Verification
The bench builds the block with its default window widths of 1, 4, 8 and 10 cycles. With these values every `ab_sel` code can be checked for its exact window length in a few dozen cycles. The single-cycle window at code 0 covers the corner where entry into and exit from the window fall on adjacent edges. The 10-cycle window at code 3 is long enough to inject an edge during the window and to observe the ungated lock low time.

// File: rtl/pfd_ab_pkg.sv
package pfd_ab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REF_AHEAD = 2'd1,
        ST_VCO_AHEAD = 2'd2,
        ST_BACKLASH  = 2'd3
    } pfd_state_t;

    localparam logic [1:0] AB_UNGATED = 2'b11;
endpackage

// File: rtl/pfd_rise_detect.sv
module pfd_rise_detect #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sig_i,
    output logic [LANES-1:0] rise_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i[g];
        end
        assign rise_o[g] = sig_i[g] & ~prev_q;
    end
endmodule

// File: rtl/pfd_backlash_timer.sv
module pfd_backlash_timer #(
    parameter int W0 = 1,
    parameter int W1 = 4,
    parameter int W2 = 8,
    parameter int W3 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic [1:0] sel_i,
    output logic       done_o
);
    localparam int MAXW01 = (W0 > W1) ? W0 : W1;
    localparam int MAXW23 = (W2 > W3) ? W2 : W3;
    localparam int MAXW   = (MAXW01 > MAXW23) ? MAXW01 : MAXW23;
    localparam int CNT_W  = $clog2(MAXW + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        unique case (sel_i)
            2'd0:    last_cnt = CNT_W'(W0 - 1);
            2'd1:    last_cnt = CNT_W'(W1 - 1);
            2'd2:    last_cnt = CNT_W'(W2 - 1);
            default: last_cnt = CNT_W'(W3 - 1);
        endcase
    end

    assign done_o = active_i && (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (active_i && !done_o) cnt_q <= cnt_q + 1'b1;
        else                        cnt_q <= '0;
    end

    // R5: the window counter never runs past the widest setting
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < MAXW);
    // R5: the counter is cleared whenever no window is being timed
    p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> cnt_q == '0);
endmodule

// File: rtl/pfd_phase_fsm.sv
module pfd_phase_fsm
    import pfd_ab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic ref_rise_i,
    input  logic vco_rise_i,
    input  logic ab_done_i,
    output logic ref_flag_o,
    output logic vco_flag_o,
    output logic backlash_o
);
    pfd_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (standby_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (ref_rise_i && vco_rise_i) st_d = ST_BACKLASH;
                    else if (ref_rise_i)          st_d = ST_REF_AHEAD;
                    else if (vco_rise_i)          st_d = ST_VCO_AHEAD;
                end
                ST_REF_AHEAD: if (vco_rise_i) st_d = ST_BACKLASH;
                ST_VCO_AHEAD: if (ref_rise_i) st_d = ST_BACKLASH;
                ST_BACKLASH:  if (ab_done_i)  st_d = ST_IDLE;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ref_flag_o = 1'b0;
        vco_flag_o = 1'b0;
        backlash_o = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_REF_AHEAD: ref_flag_o = 1'b1;
            ST_VCO_AHEAD: vco_flag_o = 1'b1;
            ST_BACKLASH: begin
                ref_flag_o = 1'b1;
                vco_flag_o = 1'b1;
                backlash_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: standby discards any pending comparison
    p_standby_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> st_q == ST_IDLE);
    // R5: the lagging edge starts the window
    p_lag_enters_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REF_AHEAD && vco_rise_i && !standby_i) |=> st_q == ST_BACKLASH);
    // R5: an expired window returns to idle
    p_window_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BACKLASH && ab_done_i && !standby_i) |=> st_q == ST_IDLE);
    // R10: a repeated leading edge keeps the lead state
    p_lead_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REF_AHEAD && !vco_rise_i && !standby_i) |=> st_q == ST_REF_AHEAD);
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash
    import pfd_ab_pkg::*;
#(
    parameter int AB_W0 = 1,
    parameter int AB_W1 = 4,
    parameter int AB_W2 = 8,
    parameter int AB_W3 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div,
    input  logic       vco_div,
    input  logic       pol_pos,
    input  logic [1:0] ab_sel,
    input  logic       standby,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output logic       lock_det
);
    localparam int LANES = 2;

    logic [LANES-1:0] rises;
    logic ref_flag, vco_flag, in_window, win_done;

    pfd_rise_detect #(.LANES(LANES)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({vco_div, ref_div}),
        .rise_o (rises)
    );

    pfd_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby),
        .ref_rise_i (rises[0]),
        .vco_rise_i (rises[1]),
        .ab_done_i  (win_done),
        .ref_flag_o (ref_flag),
        .vco_flag_o (vco_flag),
        .backlash_o (in_window)
    );

    pfd_backlash_timer #(
        .W0 (AB_W0), .W1 (AB_W1), .W2 (AB_W2), .W3 (AB_W3)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_window),
        .sel_i    (ab_sel),
        .done_o   (win_done)
    );

    always_comb begin
        if (standby) begin
            pump_up  = 1'b0;
            pump_dn  = 1'b0;
            pump_hiz = 1'b1;
            lock_det = 1'b1;
        end else begin
            pump_up  = pol_pos ? ref_flag : vco_flag;
            pump_dn  = pol_pos ? vco_flag : ref_flag;
            pump_hiz = ~(ref_flag | vco_flag);
            lock_det = ~((ref_flag ^ vco_flag) |
                         (in_window & (ab_sel == AB_UNGATED)));
        end
    end

    // R9: standby forces float and lock high
    p_standby_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> pump_hiz && lock_det && !pump_up && !pump_dn);
    // R7: a single active enable always pulls lock low
    p_single_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && (pump_up != pump_dn)) |-> !lock_det);
endmodule

// File: tb/tb_pfd_antibacklash.sv
module tb_pfd_antibacklash;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0, vco_div = 1'b0, pol_pos = 1'b1, standby = 1'b0;
    logic [1:0] ab_sel = 2'd0;
    logic pump_up, pump_dn, pump_hiz, lock_det;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pfd_antibacklash dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
        .pol_pos(pol_pos), .ab_sel(ab_sel), .standby(standby),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .lock_det(lock_det)
    );

    function automatic int win_len(input logic [1:0] code);
        case (code)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 10;
        endcase
    endfunction

    // expected {up, dn, hiz, lock}
    function automatic logic [3:0] expect_out(input bit rf, input bit vf,
            input bit pol, input logic [1:0] code, input bit stby);
        logic up, dn, hiz, lk;
        if (stby) return 4'b0011;
        up  = pol ? rf : vf;
        dn  = pol ? vf : rf;
        hiz = !(rf || vf);
        lk  = !((rf ^ vf) || (rf && vf && code == 2'd3));
        return {up, dn, hiz, lk};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {pump_up, pump_dn, pump_hiz, lock_det};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {up,dn,hiz,lock} actual %b expected %b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic run_pair(input bit ref_first, input int gap,
            input logic [1:0] code, input bit pol, input bit extra);
        int n;
        bit lead_f, lag_f, rf, vf, lead_drv, lag_drv;
        string tag;
        n = win_len(code);
        @(negedge clk);
        ab_sel = code; pol_pos = pol; ref_div = 1'b0; vco_div = 1'b0;
        @(posedge clk); #1;
        check("R3", expect_out(0, 0, pol, code, 0));
        for (int c = 0; c <= gap + n; c++) begin
            @(negedge clk);
            lead_drv = (c == 0) || (extra && gap >= 3 && c == 2) ||
                       (extra && gap >= 1 && n >= 2 && c == gap + 1);
            lag_drv  = (c == gap);
            if (ref_first) begin ref_div = lead_drv; vco_div = lag_drv; end
            else           begin vco_div = lead_drv; ref_div = lag_drv; end
            lead_f = (c < gap + n);
            lag_f  = (c >= gap) && (c < gap + n);
            rf = ref_first ? lead_f : lag_f;
            vf = ref_first ? lag_f : lead_f;
            if (!lead_f)          tag = extra ? "R3 R10" : "R3";
            else if (gap == 0)    tag = (code == 2'd3) ? "R6 R8" : "R6 R5";
            else if (!lag_f)      tag = !pol ? "R4 R7" : (ref_first ? "R1 R7" : "R2 R7");
            else                  tag = (code == 2'd3) ? "R5 R8" : (pol ? "R5 R8" : "R4 R5");
            if (extra && lead_f)  tag = {tag, " R10"};
            @(posedge clk); #1;
            check(tag, expect_out(rf, vf, pol, code, 0));
        end
        @(negedge clk);
        ref_div = 1'b0; vco_div = 1'b0;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        check("R11", expect_out(0, 0, 1, 0, 0));
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R11", expect_out(0, 0, 1, 0, 0));

        for (int code = 0; code < 4; code++) begin
            run_pair(1, 3, code[1:0], 1, 0);
            run_pair(0, 2, code[1:0], 1, 0);
            run_pair(1, 4, code[1:0], 0, 0);
            run_pair(0, 0, code[1:0], 1, 0);
        end
        run_pair(1, 5, 2'd3, 1, 1);
        run_pair(0, 4, 2'd1, 0, 1);

        // standby in the middle of a comparison
        @(negedge clk); pol_pos = 1'b1; ab_sel = 2'd1; ref_div = 1'b1;
        @(posedge clk); #1;
        check("R1 R7", expect_out(1, 0, 1, 2'd1, 0));
        @(negedge clk); ref_div = 1'b0; standby = 1'b1;
        #1 check("R9", expect_out(1, 0, 1, 2'd1, 1));
        @(posedge clk); #1;
        check("R9", expect_out(0, 0, 1, 2'd1, 1));
        @(negedge clk); vco_div = 1'b1;
        @(posedge clk); #1;
        check("R9", expect_out(0, 0, 1, 2'd1, 1));
        @(negedge clk); standby = 1'b0; vco_div = 1'b0;
        #1 check("R9", expect_out(0, 0, 1, 2'd1, 0));
        @(posedge clk); #1;
        check("R9", expect_out(0, 0, 1, 2'd1, 0));

        for (int k = 0; k < 40; k++) begin
            run_pair(bit'($urandom_range(0, 1)), $urandom_range(0, 12),
                     2'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
                     bit'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule